// File: doc/BRIEF.md
# First-and-Subsequent Error Status Logger

This block gathers error pulses from a vector of sources inside a chipset component and keeps two status registers. Each source belongs to one of two classes, fatal or non-fatal, according to a fixed parameter mask. The first-error register keeps the earliest error of each class. Every later error of a class goes to the subsequent-error register until software clears that class in the first-error register. When a class's first error is captured, a context word supplied with the error is frozen in a per-class log register.

Software uses a small register port. Each cycle it presents an address, and the read data for that address appears, registered, after the next clock edge. A write with its enable set clears, in the status register at the chosen address, each bit that is 1 in the write data. Three level interrupt outputs show pending errors in total, in the fatal class and in the non-fatal class.

Each class slot is a two-state machine. In ARMED the class has no first-error bit, and its errors go to the first-error register. In HELD the class owns at least one first-error bit, its errors go to the subsequent-error register and its log is frozen. The transition ARMED to HELD (capture) fires when any source of the class reports an error. The transition HELD to ARMED (rearm) fires when that cycle's clear-write leaves no first-error bit of the class set.

Top module: `err_status_logger`

## Requirements
- R1: After reset both status registers and both log registers read 0, all interrupt outputs are low and `rd_data` is 0.
- R2: When a class has no bit in the first-error register (address 0, bit i = source i), an error from a source of that class sets its bit there. The two classes are handled independently.
- R3: Several errors of the same empty class in one cycle all set their bits in the first-error register.
- R4: An error whose class already has a bit in the first-error register sets its bit in the subsequent-error register (address 1) and leaves the first-error register unchanged.
- R5: On capture, the class log takes the context slice `err_ctx[i*LOG_W +: LOG_W]` of the lowest-numbered erroring source i of that class. The fatal log reads at address 2 and the non-fatal log reads at address 3, zero-extended.
- R6: A class log stays unchanged while the class has any first-error bit set. It captures again only after that class is fully cleared.
- R7: A write with `wr_en` high clears each bit that is 1 in `wr_data` at address 0 or 1. Bits written 0 are unchanged, and writes to addresses 2 and 3 have no effect.
- R8: After the subsequent-error register is cleared while the class still holds first-error bits, a new error of that class lands in the subsequent-error register.
- R9: An error that arrives in the same cycle as a clear of its bit leaves that bit set.
- R10: `irq_any` is high while any bit is set in either status register. `irq_fatal` and `irq_nonfatal` are high while a bit of that class is set in either register.
- R11: `rd_data` after a clock edge holds the contents at `addr` from before that edge's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_vec | input | N_SRC | One error pulse per source |
| err_ctx | input | N_SRC*LOG_W | Context word per source, source i at slice i |
| addr | input | 2 | Register select: 0 first, 1 subsequent, 2 fatal log, 3 non-fatal log |
| wr_en | input | 1 | Clear-write strobe |
| wr_data | input | N_SRC | Write-one-to-clear mask |
| rd_data | output | RD_W | Registered read data |
| irq_any | output | 1 | Any error pending |
| irq_fatal | output | 1 | Fatal-class error pending |
| irq_nonfatal | output | 1 | Non-fatal-class error pending |

## Verification
Directed sequences try single errors per class, bursts of several same-class errors in one cycle, repeat errors after a capture, and errors that coincide with a clear. These tell first-slot routing apart from subsequent-slot routing and show whether the lowest source wins the log. A clear of the subsequent register with the first register still held separates a correct rearm condition from one keyed to the wrong register. Writes of zero and writes to the log addresses show that clears act only where intended. A long seeded random run mixes sparse errors, random reads and random clears, and compares every read and interrupt against a bench model, which catches ordering slips between clear and capture.

// File: rtl/err_log_pkg.sv
package err_log_pkg;

    typedef enum logic {
        SLOT_ARMED = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    localparam logic [1:0] ADR_FIRST = 2'd0;
    localparam logic [1:0] ADR_SUBSQ = 2'd1;
    localparam logic [1:0] ADR_LOG_F = 2'd2;
    localparam logic [1:0] ADR_LOG_N = 2'd3;

endpackage

// File: rtl/err_class_slot.sv
module err_class_slot
    import err_log_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int LOG_W = 16,
    parameter logic [N_SRC-1:0] CLS_MASK = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       err_vec,
    input  logic [N_SRC*LOG_W-1:0] err_ctx,
    input  logic [N_SRC-1:0]       keep_bits,   // class first bits surviving this cycle's clear
    output logic                   take_first,
    output logic [LOG_W-1:0]       log_q
);

    slot_state_e state_q, state_d;
    logic [N_SRC-1:0] hit;
    logic [LOG_W-1:0] low_ctx;
    logic             found;

    assign hit = err_vec & CLS_MASK;

    // lowest-numbered erroring source supplies the context
    always_comb begin
        low_ctx = '0;
        found   = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (hit[i] && !found) begin
                low_ctx = err_ctx[i*LOG_W +: LOG_W];
                found   = 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_ARMED: if (|hit)              state_d = SLOT_HELD;   // capture
            SLOT_HELD:  if (keep_bits == '0)   state_d = SLOT_ARMED;  // rearm
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_ARMED;
            log_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SLOT_ARMED && found) log_q <= low_ctx;
        end
    end

    always_comb begin
        take_first = (state_q == SLOT_ARMED);
    end

endmodule

// File: rtl/err_reg_read.sv
module err_reg_read
    import err_log_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int LOG_W = 16,
    parameter int RD_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic [N_SRC-1:0] first_q,
    input  logic [N_SRC-1:0] subsq_q,
    input  logic [LOG_W-1:0] log_f,
    input  logic [LOG_W-1:0] log_n,
    output logic [RD_W-1:0]  rd_data
);

    logic [RD_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            ADR_FIRST: rd_mux[N_SRC-1:0] = first_q;
            ADR_SUBSQ: rd_mux[N_SRC-1:0] = subsq_q;
            ADR_LOG_F: rd_mux[LOG_W-1:0] = log_f;
            ADR_LOG_N: rd_mux[LOG_W-1:0] = log_n;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_mux;
    end

endmodule

// File: rtl/err_status_logger.sv
module err_status_logger
    import err_log_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int LOG_W = 16,
    parameter logic [N_SRC-1:0] FATAL_MASK = 8'hF0,
    localparam int RD_W = (N_SRC > LOG_W) ? N_SRC : LOG_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       err_vec,
    input  logic [N_SRC*LOG_W-1:0] err_ctx,
    input  logic [1:0]             addr,
    input  logic                   wr_en,
    input  logic [N_SRC-1:0]       wr_data,
    output logic [RD_W-1:0]        rd_data,
    output logic                   irq_any,
    output logic                   irq_fatal,
    output logic                   irq_nonfatal
);

    localparam int N_CLS = 2;  // 0 fatal, 1 non-fatal

    logic [N_SRC-1:0] first_q, subsq_q, first_d, subsq_d;
    logic [N_SRC-1:0] clr_first, clr_subsq, to_first, to_subsq;
    logic [N_SRC-1:0] cls_mask [N_CLS];
    logic [N_CLS-1:0] take;
    logic [LOG_W-1:0] log_q [N_CLS];

    assign cls_mask[0] = FATAL_MASK;
    assign cls_mask[1] = ~FATAL_MASK;

    generate
        for (genvar g = 0; g < N_CLS; g++) begin : g_cls
            err_class_slot #(
                .N_SRC   (N_SRC),
                .LOG_W   (LOG_W),
                .CLS_MASK((g == 0) ? FATAL_MASK : ~FATAL_MASK)
            ) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .err_vec   (err_vec),
                .err_ctx   (err_ctx),
                .keep_bits (first_q & cls_mask[g] & ~clr_first),
                .take_first(take[g]),
                .log_q     (log_q[g])
            );
        end
    endgenerate

    always_comb begin
        clr_first = (wr_en && addr == ADR_FIRST) ? wr_data : '0;
        clr_subsq = (wr_en && addr == ADR_SUBSQ) ? wr_data : '0;
        to_first  = (take[0] ? (err_vec & cls_mask[0]) : '0)
                  | (take[1] ? (err_vec & cls_mask[1]) : '0);
        to_subsq  = err_vec & ~to_first;
        first_d   = (first_q & ~clr_first) | to_first;   // new error beats clear
        subsq_d   = (subsq_q & ~clr_subsq) | to_subsq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q <= '0;
            subsq_q <= '0;
        end else begin
            first_q <= first_d;
            subsq_q <= subsq_d;
        end
    end

    err_reg_read #(
        .N_SRC(N_SRC),
        .LOG_W(LOG_W),
        .RD_W (RD_W)
    ) u_read (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .first_q(first_q),
        .subsq_q(subsq_q),
        .log_f  (log_q[0]),
        .log_n  (log_q[1]),
        .rd_data(rd_data)
    );

    always_comb begin
        irq_fatal    = |((first_q | subsq_q) & cls_mask[0]);
        irq_nonfatal = |((first_q | subsq_q) & cls_mask[1]);
        irq_any      = irq_fatal | irq_nonfatal;
    end

endmodule

// File: rtl/err_status_logger_chk.sv
module err_status_logger_chk #(
    parameter int N_SRC = 8,
    parameter int LOG_W = 16,
    parameter logic [N_SRC-1:0] FATAL_MASK = 8'hF0
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] err_vec,
    input logic [N_SRC-1:0] first_q,
    input logic [N_SRC-1:0] subsq_q,
    input logic [LOG_W-1:0] log_f,
    input logic [LOG_W-1:0] log_n,
    input logic             irq_any
);

    AST_FIRST_ONLY_FROM_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ((first_q & ~$past(first_q) & ~$past(err_vec)) == '0)); // R2

    AST_ERR_NEVER_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_vec) |=> ((($past(err_vec)) & ~(first_q | subsq_q)) == '0)); // R9

    AST_SUBSQ_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((subsq_q & ~$past(subsq_q) & FATAL_MASK) != '0) |-> $past(|(first_q & FATAL_MASK))); // R4

    AST_LOG_F_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(|(first_q & FATAL_MASK)) |-> $stable(log_f)); // R6

    AST_LOG_N_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(|(first_q & ~FATAL_MASK)) |-> $stable(log_n)); // R6

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_any) |-> $past(|err_vec)); // R10

endmodule

bind err_status_logger err_status_logger_chk #(
    .N_SRC     (N_SRC),
    .LOG_W     (LOG_W),
    .FATAL_MASK(FATAL_MASK)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_vec(err_vec),
    .first_q(first_q),
    .subsq_q(subsq_q),
    .log_f  (log_q[0]),
    .log_n  (log_q[1]),
    .irq_any(irq_any)
);

// File: tb/tb_err_status_logger.sv
module tb_err_status_logger;

    localparam int N  = 8;
    localparam int LW = 16;
    localparam int RW = 16;
    localparam logic [N-1:0] FM = 8'hF0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    err_vec = '0;
    logic [N*LW-1:0] err_ctx = '0;
    logic [1:0]      addr = '0;
    logic            wr_en = 1'b0;
    logic [N-1:0]    wr_data = '0;
    logic [RW-1:0]   rd_data;
    logic            irq_any, irq_fatal, irq_nonfatal;

    always #2 clk = ~clk;  // 250 MHz

    err_status_logger #(.N_SRC(N), .LOG_W(LW), .FATAL_MASK(FM)) dut (
        .clk(clk), .rst_n(rst_n), .err_vec(err_vec), .err_ctx(err_ctx),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_any(irq_any), .irq_fatal(irq_fatal), .irq_nonfatal(irq_nonfatal)
    );

    int checks = 0;
    int fails  = 0;

    logic [N-1:0]  m_first = '0, m_subsq = '0;
    logic [LW-1:0] m_logf = '0, m_logn = '0;

    function automatic logic [LW-1:0] low_ctx(logic [N-1:0] h, logic [N*LW-1:0] c);
        for (int i = 0; i < N; i++) if (h[i]) return c[i*LW +: LW];
        return '0;
    endfunction

    function automatic logic [RW-1:0] model_read(logic [1:0] a);
        logic [RW-1:0] r = '0;
        case (a)
            2'd0: r[N-1:0] = m_first;
            2'd1: r[N-1:0] = m_subsq;
            2'd2: r = m_logf;
            default: r = m_logn;
        endcase
        return r;
    endfunction

    task automatic check(string tag, logic [RW-1:0] act, logic [RW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(logic [N-1:0] e, logic [N*LW-1:0] c, logic [1:0] a,
                       logic we, logic [N-1:0] w, string tag);
        logic [RW-1:0] exp_rd;
        logic [N-1:0] tf, tn, to_first, clr_f, clr_s;
        @(negedge clk);
        err_vec = e; err_ctx = c; addr = a; wr_en = we; wr_data = w;
        @(posedge clk);
        #1;
        exp_rd   = model_read(a);
        tf       = ((m_first & FM) == '0) ? (e & FM) : '0;
        tn       = ((m_first & ~FM) == '0) ? (e & ~FM) : '0;
        to_first = tf | tn;
        if (tf != '0) m_logf = low_ctx(tf, c);
        if (tn != '0) m_logn = low_ctx(tn, c);
        clr_f    = (we && a == 2'd0) ? w : '0;
        clr_s    = (we && a == 2'd1) ? w : '0;
        m_first  = (m_first & ~clr_f) | to_first;
        m_subsq  = (m_subsq & ~clr_s) | (e & ~to_first);
        check({tag, " rd"}, rd_data, exp_rd);
        check("R10 irq_any", {15'd0, irq_any}, {15'd0, |(m_first | m_subsq)});
        check("R10 irq_fatal", {15'd0, irq_fatal}, {15'd0, |((m_first | m_subsq) & FM)});
        check("R10 irq_nonfatal", {15'd0, irq_nonfatal}, {15'd0, |((m_first | m_subsq) & ~FM)});
    endtask

    function automatic logic [N*LW-1:0] rnd_ctx();
        logic [N*LW-1:0] c;
        for (int i = 0; i < N; i++) c[i*LW +: LW] = LW'($urandom);
        return c;
    endfunction

    task automatic idle_read(logic [1:0] a, string tag);
        cyc('0, '0, a, 1'b0, '0, tag);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [N*LW-1:0] c;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 rd reset", rd_data, '0);
        check("R1 irq reset", {13'd0, irq_any, irq_fatal, irq_nonfatal}, '0);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) idle_read(2'(a), "R1");

        // R2: one fatal and one non-fatal first error together
        c = rnd_ctx();
        cyc(8'h22, c, 2'd0, 1'b0, '0, "R2");
        idle_read(2'd0, "R2");
        check("R2 first value", rd_data, 16'h0022);
        idle_read(2'd2, "R5");
        check("R5 fatal log", rd_data, c[5*LW +: LW]);

        // R3/R5: burst of non-fatal errors into an empty class
        cyc('0, '0, 2'd0, 1'b1, 8'hFF, "R7");
        c = rnd_ctx();
        cyc(8'h0C, c, 2'd3, 1'b0, '0, "R3");
        idle_read(2'd3, "R5");
        check("R5 lowest source ctx", rd_data, c[2*LW +: LW]);
        idle_read(2'd0, "R3");
        check("R3 both bits first", rd_data, 16'h000C);

        // R4/R6: repeat error goes to subsequent, log frozen
        cyc(8'h08, rnd_ctx(), 2'd1, 1'b0, '0, "R4");
        idle_read(2'd1, "R4");
        check("R4 subsequent bit", rd_data, 16'h0008);
        idle_read(2'd3, "R6");
        check("R6 log frozen", rd_data, c[2*LW +: LW]);

        // R8: clear subsequent while first held, new error still subsequent
        cyc('0, '0, 2'd1, 1'b1, 8'hFF, "R8");
        cyc(8'h01, rnd_ctx(), 2'd0, 1'b0, '0, "R8");
        idle_read(2'd1, "R8");
        check("R8 lands subsequent", rd_data, 16'h0001);

        // R9: error coincides with its own clear
        cyc(8'h01, rnd_ctx(), 2'd1, 1'b1, 8'h01, "R9");
        idle_read(2'd1, "R9");
        check("R9 bit survives", rd_data, 16'h0001);

        // R7: zero writes and log-address writes change nothing
        cyc('0, '0, 2'd0, 1'b1, 8'h00, "R7");
        cyc('0, '0, 2'd3, 1'b1, 8'hFF, "R7");
        idle_read(2'd0, "R7");
        check("R7 first kept", rd_data, 16'h000C);
        idle_read(2'd3, "R7");
        check("R7 log kept", rd_data, c[2*LW +: LW]);

        // R6: rearm after full non-fatal clear
        cyc('0, '0, 2'd0, 1'b1, 8'h0C, "R6");
        c = rnd_ctx();
        cyc(8'h02, c, 2'd0, 1'b0, '0, "R6");
        idle_read(2'd3, "R6");
        check("R6 recapture", rd_data, c[1*LW +: LW]);

        // constrained random mix, checked against the model (R11)
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] e;
            e = '0;
            for (int b = 0; b < N; b++) e[b] = ($urandom_range(0, 15) == 0);
            cyc(e, rnd_ctx(), 2'($urandom_range(0, 3)), ($urandom_range(0, 2) == 0),
                N'($urandom), "R11");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule